// File: doc/BRIEF.md
# Twelve-Hour Time-of-Day Counter

This block keeps wall-clock time from a slow pulse derived from the 60 Hz mains. It runs on a fast synchronous system clock. The mains pulse is not related to that clock, so the block first passes it through a flop synchroniser. It then turns each 1-to-0 transition into a single-cycle enable. Two rate dividers, one dividing by six and one by ten, reduce those enables to one tick per second. That tick drives a chain of BCD digit counters for seconds and minutes, and a twelve-hour hours counter. All six digits are outputs, ready for an external decoder.

The hours counter never shows 00 or 13. Internally the hours first step from 12 to 13. On the following clock the 13 is cleared to 00, and on the clock after that the 00 is loaded with 01. The load is a separate cycle from the one that carried in from the minutes, so the two never meet. The hours outputs come from a shadow register that copies the internal count only when no correction is pending. A one-cycle advance input moves the hours forward through the same path, which is how the clock is set.

Top module: `mains_tod_counter`

## Requirements
- R1: A synchronous reset sets the outputs to 12:00:00, visible one clock after the reset edge.
- R2: Only 1-to-0 transitions of `mains_in` advance the time. A rising transition, or a level held for any length of time, has no effect. Each transition is counted once.
- R3: With the default dividers, exactly 60 falling transitions produce one seconds increment, and 59 produce none.
- R4: Seconds and minutes are each two BCD digits. The ones digit runs 0 to 9 and the tens digit 0 to 5. The value 59 rolls to 00 and carries into the next field.
- R5: Hours are two BCD digits holding 1 to 12. The tens digit is 0 or 1, and 9 steps to 10.
- R6: Hours go from 12 to 01. The outputs never show 00 or 13. Internally the rollover is a clear of 13 to 00, followed on the next clock by a load of 01.
- R7: Each clock cycle with `hour_adv` high advances the hours by one, through the same rollover, and leaves minutes and seconds untouched.
- R8: A `hour_adv` cycle that falls while a rollover correction (internal 13 or 00) is pending is ignored.
- R9: A seconds tick at 12:59:59 gives 01:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mains_in | input | 1 | Asynchronous mains-derived timebase pulse |
| hour_adv | input | 1 | Advance hours by one per cycle high |
| sec_ones | output | 4 | Seconds ones digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes ones digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours ones digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |

## Verification
A divider phase that is off by one does not show up at once. It appears only as a seconds step one pulse too early or too late, and at worst that is 60 input pulses after the fault. A wrong hours correction shows within four system clocks of the minute carry, as a displayed 00, 13 or 02 after 12. A digit counter with the wrong limit shows as a digit that is out of range, or a carry that is missed, on the first pass through 9 or 5. The fast-divider instance reaches the hour rollover in a few thousand cycles, so these faults surface early.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef logic [3:0] bcd_t;

  // two-digit BCD increment without range limit
  function automatic logic [7:0] bcd2_inc(input bcd_t hi, input bcd_t lo);
    if (lo == 4'd9) return {hi + 4'd1, 4'd0};
    return {hi, lo + 4'd1};
  endfunction

  // numeric value of a two-digit BCD pair
  function automatic logic [7:0] bcd2_val(input bcd_t hi, input bcd_t lo);
    return 8'(hi) * 8'd10 + 8'(lo);
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall_en
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_en = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/rate_div.sv
module rate_div #(
  parameter int N = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse
);
  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] TOP = W'(N - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (en) cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + W'(1);
  end

  assign pulse = en & (cnt_q == TOP);
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit #(
  parameter int LAST = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [3:0] val,
  output logic       carry
);
  localparam logic [3:0] TOP = 4'(LAST);

  always_ff @(posedge clk) begin
    if (rst) val <= 4'd0;
    else if (en) val <= (val == TOP) ? 4'd0 : val + 4'd1;
  end

  assign carry = en & (val == TOP);
endmodule

// File: rtl/hour_unit.sv
module hour_unit
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  output bcd_t raw_hi,
  output bcd_t raw_lo,
  output bcd_t show_hi,
  output bcd_t show_lo,
  output logic at13,
  output logic at00,
  output logic busy
);
  assign at13 = (bcd2_val(raw_hi, raw_lo) == 8'd13);
  assign at00 = (bcd2_val(raw_hi, raw_lo) == 8'd0);
  assign busy = at13 | at00;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_hi  <= 4'd1;
      raw_lo  <= 4'd2;
      show_hi <= 4'd1;
      show_lo <= 4'd2;
    end else begin
      if (at13) begin
        raw_hi <= 4'd0;
        raw_lo <= 4'd0;
      end else if (at00) begin
        raw_hi <= 4'd0;
        raw_lo <= 4'd1;
      end else if (step) begin
        {raw_hi, raw_lo} <= bcd2_inc(raw_hi, raw_lo);
      end
      if (!busy) begin
        show_hi <= raw_hi;
        show_lo <= raw_lo;
      end
    end
  end
endmodule

// File: rtl/mains_tod_counter.sv
module mains_tod_counter #(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_DIV     = 6,
  parameter int SEC_DIV     = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mains_in,
  input  logic       hour_adv,
  output logic [3:0] sec_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [3:0] min_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] hr_tens
);
  import tod_pkg::*;

  localparam int NDIG = 4;

  logic fall_en, tenth_tick, sec_tick, hour_step;
  logic [NDIG:0] carry;
  bcd_t digit [NDIG];
  bcd_t hr_raw_hi, hr_raw_lo;
  logic hr_at13, hr_at00, hr_busy;

  edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(mains_in), .fall_en(fall_en)
  );

  rate_div #(.N(PRE_DIV)) u_div_pre (
    .clk(clk), .rst(rst), .en(fall_en), .pulse(tenth_tick)
  );

  rate_div #(.N(SEC_DIV)) u_div_sec (
    .clk(clk), .rst(rst), .en(tenth_tick), .pulse(sec_tick)
  );

  assign carry[0] = sec_tick;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    bcd_digit #(.LAST((g % 2 == 0) ? 9 : 5)) u_digit (
      .clk(clk), .rst(rst), .en(carry[g]),
      .val(digit[g]), .carry(carry[g+1])
    );
  end

  assign hour_step = carry[NDIG] | hour_adv;

  hour_unit u_hours (
    .clk(clk), .rst(rst), .step(hour_step),
    .raw_hi(hr_raw_hi), .raw_lo(hr_raw_lo),
    .show_hi(hr_tens), .show_lo(hr_ones),
    .at13(hr_at13), .at00(hr_at00), .busy(hr_busy)
  );

  assign sec_ones = digit[0];
  assign sec_tens = digit[1];
  assign min_ones = digit[2];
  assign min_tens = digit[3];
endmodule

// File: rtl/tod_checks.sv
module tod_checks (
  input logic       clk,
  input logic       rst,
  input logic       fall_en,
  input logic       sec_tick,
  input logic       at13,
  input logic       at00,
  input logic [3:0] raw_hi,
  input logic [3:0] raw_lo,
  input logic [3:0] sec_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] min_ones,
  input logic [3:0] min_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] hr_tens
);
  logic [7:0] shown_hr;
  assign shown_hr = 8'(hr_tens) * 8'd10 + 8'(hr_ones);

  assert_reset_time_R1: assert property (@(posedge clk)
    rst |=> (shown_hr == 8'd12 && min_tens == 4'd0 && min_ones == 4'd0 &&
             sec_tens == 4'd0 && sec_ones == 4'd0));

  assert_single_enable_R2: assert property (@(posedge clk) disable iff (rst)
    fall_en |=> !fall_en);

  assert_tick_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> fall_en);

  assert_digit_range_R4: assert property (@(posedge clk) disable iff (rst)
    sec_ones <= 4'd9 && sec_tens <= 4'd5 && min_ones <= 4'd9 && min_tens <= 4'd5);

  assert_hour_range_R5: assert property (@(posedge clk) disable iff (rst)
    shown_hr >= 8'd1 && shown_hr <= 8'd12 && hr_tens <= 4'd1 && hr_ones <= 4'd9);

  assert_clear_after_13_R6: assert property (@(posedge clk) disable iff (rst)
    at13 |=> at00);

  assert_load_after_00_R6: assert property (@(posedge clk) disable iff (rst)
    at00 |=> (raw_hi == 4'd0 && raw_lo == 4'd1));

  assert_wrap_to_one_R6: assert property (@(posedge clk) disable iff (rst)
    (shown_hr == 8'd12) |=> (shown_hr == 8'd12 || shown_hr == 8'd1));
endmodule

bind mains_tod_counter tod_checks u_tod_checks (
  .clk(clk), .rst(rst), .fall_en(fall_en), .sec_tick(sec_tick),
  .at13(hr_at13), .at00(hr_at00), .raw_hi(hr_raw_hi), .raw_lo(hr_raw_lo),
  .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
  .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens)
);

// File: tb/test_mains_tod_counter.sv
module test_mains_tod_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mains_a = 1'b0, mains_b = 1'b0;
  logic adv_a = 1'b0, adv_b = 1'b0;
  logic [3:0] a_so, a_st, a_mo, a_mt, a_ho, a_ht;
  logic [3:0] b_so, b_st, b_mo, b_mt, b_ho, b_ht;

  int checks = 0;
  int fails = 0;
  int unsigned falls_a = 0, adds_a = 0, secs_b = 0;
  int unsigned seed_val;

  always #10 clk = ~clk;

  mains_tod_counter i_mains_tod_counter (
    .clk(clk), .rst(rst), .mains_in(mains_a), .hour_adv(adv_a),
    .sec_ones(a_so), .sec_tens(a_st), .min_ones(a_mo), .min_tens(a_mt),
    .hr_ones(a_ho), .hr_tens(a_ht)
  );

  // dividers of one: every falling edge is one second
  mains_tod_counter #(.PRE_DIV(1), .SEC_DIV(1)) i_mains_tod_counter_fast (
    .clk(clk), .rst(rst), .mains_in(mains_b), .hour_adv(adv_b),
    .sec_ones(b_so), .sec_tens(b_st), .min_ones(b_mo), .min_tens(b_mt),
    .hr_ones(b_ho), .hr_tens(b_ht)
  );

  // expected digits {hr_tens,hr_ones,min_tens,min_ones,sec_tens,sec_ones}
  function automatic logic [23:0] expect_time(input int unsigned secs);
    int unsigned h, m, s;
    h = (secs / 3600) % 12;
    if (h == 0) h = 12;
    m = (secs / 60) % 60;
    s = secs % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  function automatic logic [23:0] exp_a();
    return expect_time(falls_a / 60 + adds_a * 3600);
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic fall_a(input int hi, input int lo);
    mains_a = 1'b1;
    repeat (hi) @(negedge clk);
    mains_a = 1'b0;
    repeat (lo) @(negedge clk);
    falls_a++;
  endtask

  task automatic fall_b(input int n);
    for (int i = 0; i < n; i++) begin
      mains_b = 1'b1;
      @(negedge clk);
      mains_b = 1'b0;
      @(negedge clk);
      secs_b++;
    end
  endtask

  task automatic pulse_adv_a();
    adv_a = 1'b1;
    @(negedge clk);
    adv_a = 1'b0;
    repeat (6) @(negedge clk);
    adds_a++;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  wire [23:0] a_now = {a_ht, a_ho, a_mt, a_mo, a_st, a_so};
  wire [23:0] b_now = {b_ht, b_ho, b_mt, b_mo, b_st, b_so};

  initial begin
    seed_val = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset main", a_now, 24'h120000);
    check("R1 reset fast", b_now, 24'h120000);

    // R3: 59 edges give no increment
    for (int i = 0; i < 59; i++) fall_a(2, 2);
    settle();
    check("R3 59 edges", a_now, 24'h120000);

    // R2: a rising edge and a long high level do not count
    mains_a = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 rise ignored", a_now, 24'h120000);
    mains_a = 1'b0;
    falls_a++;
    settle();
    check("R2 R3 60th edge", a_now, 24'h120001);

    // R2 R3 R4: random pulse widths
    for (int b = 0; b < 8; b++) begin
      int n;
      n = $urandom_range(150, 30);
      for (int i = 0; i < n; i++) fall_a($urandom_range(3, 1), $urandom_range(3, 1));
      settle();
      check("R3 R4 random pulses", a_now, exp_a());
    end

    // R5 R6 R7: hour advance round the dial
    for (int i = 0; i < 13; i++) begin
      pulse_adv_a();
      check("R5 R6 R7 hour advance", a_now, exp_a());
    end

    // R8: bring hours to 12, then two back-to-back advance cycles
    while ((adds_a % 12) != 0) pulse_adv_a();
    check("R7 at twelve", a_now[23:16], 8'h12);
    adv_a = 1'b1;
    repeat (2) @(negedge clk);
    adv_a = 1'b0;
    adds_a++;
    settle();
    check("R8 second advance ignored", a_now, exp_a());

    // fast instance from a fresh reset
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    falls_a = 0;
    adds_a = 0;
    secs_b = 0;
    @(negedge clk);
    check("R1 second reset", a_now, 24'h120000);

    fall_b(59);
    settle();
    check("R4 seconds 59", b_now, expect_time(secs_b));
    fall_b(1);
    settle();
    check("R4 carry to minute", b_now, 24'h120100);
    fall_b(3599 - secs_b);
    settle();
    check("R4 R9 at 12:59:59", b_now, 24'h125959);
    fall_b(1);
    settle();
    check("R6 R9 wrap to one", b_now, 24'h010000);

    for (int b = 0; b < 10; b++) begin
      fall_b($urandom_range(800, 1));
      settle();
      check("R4 R5 R6 random seconds", b_now, expect_time(secs_b));
    end

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end
endmodule